// File: doc/BRIEF.md
# Upstream Read Request Admission Tracker

This block sits between a parallel bus segment and a serial upstream link. It decides, in the cycle a read request is presented, whether that request may go upstream now or must be refused and retried later. It keeps a count of outstanding requests for each read stream and for the whole segment. In split-transaction mode it also owns a pool of 512-byte buffer chunks and hands one out per request. For each request it admits, it gives the byte length to issue upstream. That length is clipped so that a prefetch never crosses a 4 KB page.

The bus mode picks the allocation policy. In conventional mode every stream has one fixed 1 KB buffer of its own, and a request may ask for at most that much. In split-transaction mode a request takes the lowest-numbered free 512-byte chunk. A stream may hold any number of chunks, and only its request limit caps it. Completions return through a separate port. They free the chunk or the stream slot, even while the segment is locked.

Top module: `rdtrk_top`

## Requirements
- R1: In conventional mode (split_mode = 0) a stream with 4 requests outstanding has any further request refused. A completion on that stream (cpl_valid with cpl_stream) frees one slot.
- R2: In both modes the segment as a whole has at most 8 requests outstanding. The ninth request is refused even when its own stream has room.
- R3: In split-transaction mode (split_mode = 1) each admitted request takes the lowest-numbered free chunk, reported on req_chunk. A stream may hold several chunks, limited only by its 4-request cap, and a request is refused when no chunk is free. In conventional mode req_chunk is 0.
- R4: In split-transaction mode a completion names a chunk on cpl_chunk. If that chunk is busy, it is freed and one outstanding request of the stream that owns it is retired, whatever cpl_stream says. A completion naming a free chunk changes nothing.
- R5: req_issue_len is the smallest of three values: req_len, the bytes left before the next 4096-byte boundary above req_addr, and the buffer capacity (1024 bytes in conventional mode, 512 in split-transaction mode).
- R6: While bus_locked is 1, every request is refused. Completions are still accepted and retire outstanding requests.
- R7: Every presented request gets, combinationally in the same cycle, exactly one of req_grant or req_refuse. A refused request changes no state.
- R8: In conventional mode a completion for a stream with nothing outstanding is ignored, and no count goes below zero.
- R9: After reset no request is outstanding and every chunk is free. The first request is granted, and in split-transaction mode it receives chunk 0.
- R10: When a grant and a completion hit the same stream in the same cycle, the stream count and the segment count stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode | input | 1 | 0 conventional, 1 split-transaction; changed only while idle |
| bus_locked | input | 1 | Segment locked; blocks new requests |
| req_valid | input | 1 | A read request is presented |
| req_stream | input | 2 | Stream index of the request |
| req_addr | input | 32 | Start byte address of the request |
| req_len | input | 13 | Requested length in bytes |
| req_grant | output | 1 | Request admitted this cycle |
| req_refuse | output | 1 | Request refused this cycle |
| req_issue_len | output | 13 | Byte length to issue upstream |
| req_chunk | output | 3 | Chunk allocated (split mode), else 0 |
| cpl_valid | input | 1 | Last completion data for one request returned |
| cpl_stream | input | 2 | Stream of the completion (conventional mode) |
| cpl_chunk | input | 3 | Chunk of the completion (split mode) |

## Verification
The bench fills a stream up to its cap and then a segment up to its cap. It checks that the next request is refused and that one completion frees exactly one slot. A design with an off-by-one limit would admit a fifth or ninth request, and one that counted refused requests would refuse too early. It sends stray completions: to an empty stream, and to a free chunk. A counter that went below zero or decremented on a free chunk would then admit more requests than the caps allow. It presents addresses near a page end with both buffer capacities, holds the lock while a completion arrives, and drives a grant and a completion on the same stream in the same cycle. A design that dropped either event would be off by one slot afterwards.

// File: rtl/rdtrk_pkg.sv
package rdtrk_pkg;

   typedef enum logic {
      MODE_CONV  = 1'b0,
      MODE_SPLIT = 1'b1
   } rd_mode_e;

   function automatic int unsigned umin(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/rdtrk_clip.sv
module rdtrk_clip
   import rdtrk_pkg::*;
#(
   parameter int PAGE_BYTES  = 4096,
   parameter int CONV_BUF    = 1024,
   parameter int CHUNK_BYTES = 512,
   parameter int LENW        = 13,
   parameter bit SPLIT_EN    = 1'b1,
   localparam int POW        = $clog2(PAGE_BYTES)
) (
   input  logic [POW-1:0]  page_off,
   input  logic [LENW-1:0] len_in,
   input  rd_mode_e        mode,
   output logic [LENW-1:0] len_out
);

   int unsigned remain;
   int unsigned cap;

   generate
      if (SPLIT_EN) begin : g_dual_cap
         always_comb cap = (mode == MODE_SPLIT) ? CHUNK_BYTES : CONV_BUF;
      end else begin : g_conv_cap
         logic unused_mode;
         assign unused_mode = mode;
         always_comb cap = CONV_BUF;
      end
   endgenerate

   always_comb begin
      remain  = PAGE_BYTES - int'(page_off);
      len_out = LENW'(umin(umin(int'(len_in), remain), cap));
   end

endmodule

// File: rtl/rdtrk_pool.sv
module rdtrk_pool #(
   parameter int NUM_CHUNKS  = 8,
   parameter int NUM_STREAMS = 4,
   localparam int CIDW       = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
   localparam int SIDW       = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            alloc_en,
   input  logic [SIDW-1:0] alloc_stream,
   input  logic            rel_en,
   input  logic [CIDW-1:0] rel_chunk,
   output logic            free_any,
   output logic [CIDW-1:0] free_idx,
   output logic            rel_hit,
   output logic [SIDW-1:0] rel_owner
);

   logic [NUM_CHUNKS-1:0] busy_q;
   logic [SIDW-1:0]       owner_q [NUM_CHUNKS];

   // lowest-numbered free chunk
   always_comb begin
      free_any = 1'b0;
      free_idx = '0;
      for (int i = NUM_CHUNKS - 1; i >= 0; i--) begin
         if (!busy_q[i]) begin
            free_any = 1'b1;
            free_idx = CIDW'(i);
         end
      end
   end

   always_comb begin
      rel_hit   = 1'b0;
      rel_owner = '0;
      for (int i = 0; i < NUM_CHUNKS; i++) begin
         if (rel_en && rel_chunk == CIDW'(i) && busy_q[i]) begin
            rel_hit   = 1'b1;
            rel_owner = owner_q[i];
         end
      end
   end

   generate
      for (genvar c = 0; c < NUM_CHUNKS; c++) begin : g_chunk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q[c]  <= 1'b0;
               owner_q[c] <= '0;
            end else if (alloc_en && free_any && free_idx == CIDW'(c)) begin
               busy_q[c]  <= 1'b1;
               owner_q[c] <= alloc_stream;
            end else if (rel_hit && rel_chunk == CIDW'(c)) begin
               busy_q[c]  <= 1'b0;
            end
         end
      end
   endgenerate

   // R3
   alloc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_en |=> busy_q[$past(free_idx)]);

   // R4
   release_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_hit |=> !busy_q[$past(rel_chunk)]);

endmodule

// File: rtl/rdtrk_counts.sv
module rdtrk_counts #(
   parameter int NUM_STREAMS = 4,
   parameter int STREAM_MAX  = 4,
   parameter int SEG_MAX     = 8,
   localparam int SIDW       = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
   localparam int CNTW       = $clog2(STREAM_MAX + 1),
   localparam int SEGW       = $clog2(SEG_MAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            inc_en,
   input  logic [SIDW-1:0] inc_stream,
   input  logic            dec_en,
   input  logic [SIDW-1:0] dec_stream,
   input  logic [SIDW-1:0] query_stream,
   output logic            stream_full,
   output logic            seg_full
);

   logic [CNTW-1:0] cnt_q [NUM_STREAMS];
   logic [SEGW-1:0] seg_q;
   logic            dec_ok;

   always_comb begin
      stream_full = (int'(query_stream) >= NUM_STREAMS);
      dec_ok      = 1'b0;
      for (int s = 0; s < NUM_STREAMS; s++) begin
         if (query_stream == SIDW'(s) && cnt_q[s] == CNTW'(STREAM_MAX))
            stream_full = 1'b1;
         if (dec_en && dec_stream == SIDW'(s) && cnt_q[s] != '0)
            dec_ok = 1'b1;
      end
      seg_full = (seg_q == SEGW'(SEG_MAX));
   end

   generate
      for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_stream
         logic inc_hit;
         logic dec_hit;
         assign inc_hit = inc_en && inc_stream == SIDW'(s);
         assign dec_hit = dec_ok && dec_stream == SIDW'(s);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  cnt_q[s] <= '0;
            else if (inc_hit && !dec_hit) cnt_q[s] <= cnt_q[s] + 1'b1;
            else if (dec_hit && !inc_hit) cnt_q[s] <= cnt_q[s] - 1'b1;
         end

         // R1
         stream_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[s] <= CNTW'(STREAM_MAX));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 seg_q <= '0;
      else if (inc_en && !dec_ok) seg_q <= seg_q + 1'b1;
      else if (dec_ok && !inc_en) seg_q <= seg_q - 1'b1;
   end

   int unsigned cnt_sum;
   always_comb begin
      cnt_sum = 0;
      for (int s = 0; s < NUM_STREAMS; s++) cnt_sum += int'(cnt_q[s]);
   end

   // R2
   seg_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seg_q <= SEGW'(SEG_MAX));

   // R10
   seg_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(seg_q) == cnt_sum);

endmodule

// File: rtl/rdtrk_top.sv
module rdtrk_top
   import rdtrk_pkg::*;
#(
   parameter int NUM_STREAMS = 4,
   parameter int STREAM_MAX  = 4,
   parameter int SEG_MAX     = 8,
   parameter int NUM_CHUNKS  = 8,
   parameter int AW          = 32,
   parameter int LENW        = 13,
   parameter int PAGE_BYTES  = 4096,
   parameter int CONV_BUF    = 1024,
   parameter int CHUNK_BYTES = 512,
   parameter bit SPLIT_EN    = 1'b1,
   localparam int SIDW       = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
   localparam int CIDW       = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1,
   localparam int POW        = $clog2(PAGE_BYTES)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            split_mode,
   input  logic            bus_locked,
   input  logic            req_valid,
   input  logic [SIDW-1:0] req_stream,
   input  logic [AW-1:0]   req_addr,
   input  logic [LENW-1:0] req_len,
   output logic            req_grant,
   output logic            req_refuse,
   output logic [LENW-1:0] req_issue_len,
   output logic [CIDW-1:0] req_chunk,
   input  logic            cpl_valid,
   input  logic [SIDW-1:0] cpl_stream,
   input  logic [CIDW-1:0] cpl_chunk
);

   // elaboration-time parameter checks
   if (LENW <= POW) begin : g_bad_lenw
      $error("LENW must hold a full page length");
   end
   if (STREAM_MAX > SEG_MAX) begin : g_bad_caps
      $error("per-stream cap exceeds segment cap");
   end
   if (CONV_BUF > PAGE_BYTES || CHUNK_BYTES > PAGE_BYTES) begin : g_bad_buf
      $error("buffer capacity exceeds page size");
   end
   if (AW <= POW) begin : g_bad_aw
      $error("address narrower than a page offset");
   end

   rd_mode_e        mode;
   logic            stream_full;
   logic            seg_full;
   logic            chunk_ok;
   logic            refuse_cond;
   logic            dec_en;
   logic [SIDW-1:0] dec_stream;
   logic            unused_addr_hi;

   assign unused_addr_hi = ^req_addr[AW-1:POW];

   generate
      if (SPLIT_EN) begin : g_split
         logic            free_any;
         logic [CIDW-1:0] free_idx;
         logic            rel_hit;
         logic [SIDW-1:0] rel_owner;

         assign mode = rd_mode_e'(split_mode);

         rdtrk_pool #(
            .NUM_CHUNKS  (NUM_CHUNKS),
            .NUM_STREAMS (NUM_STREAMS)
         ) u_pool (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_en     (req_grant && mode == MODE_SPLIT),
            .alloc_stream (req_stream),
            .rel_en       (cpl_valid && mode == MODE_SPLIT),
            .rel_chunk    (cpl_chunk),
            .free_any     (free_any),
            .free_idx     (free_idx),
            .rel_hit      (rel_hit),
            .rel_owner    (rel_owner)
         );

         always_comb begin
            if (mode == MODE_SPLIT) begin
               chunk_ok   = free_any;
               req_chunk  = free_idx;
               dec_en     = rel_hit;
               dec_stream = rel_owner;
            end else begin
               chunk_ok   = 1'b1;
               req_chunk  = '0;
               dec_en     = cpl_valid;
               dec_stream = cpl_stream;
            end
         end
      end else begin : g_conv_only
         logic unused_split;
         assign unused_split = split_mode ^ (^cpl_chunk);
         assign mode       = MODE_CONV;
         assign chunk_ok   = 1'b1;
         assign req_chunk  = '0;
         assign dec_en     = cpl_valid;
         assign dec_stream = cpl_stream;
      end
   endgenerate

   rdtrk_counts #(
      .NUM_STREAMS (NUM_STREAMS),
      .STREAM_MAX  (STREAM_MAX),
      .SEG_MAX     (SEG_MAX)
   ) u_counts (
      .clk          (clk),
      .rst_n        (rst_n),
      .inc_en       (req_grant),
      .inc_stream   (req_stream),
      .dec_en       (dec_en),
      .dec_stream   (dec_stream),
      .query_stream (req_stream),
      .stream_full  (stream_full),
      .seg_full     (seg_full)
   );

   rdtrk_clip #(
      .PAGE_BYTES  (PAGE_BYTES),
      .CONV_BUF    (CONV_BUF),
      .CHUNK_BYTES (CHUNK_BYTES),
      .LENW        (LENW),
      .SPLIT_EN    (SPLIT_EN)
   ) u_clip (
      .page_off (req_addr[POW-1:0]),
      .len_in   (req_len),
      .mode     (mode),
      .len_out  (req_issue_len)
   );

   assign refuse_cond = bus_locked || stream_full || seg_full || !chunk_ok;
   assign req_grant   = req_valid && !refuse_cond;
   assign req_refuse  = req_valid && refuse_cond;

   // R7
   grant_refuse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> $onehot({req_grant, req_refuse}));

   // R6
   lock_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_locked |-> !req_grant);

   // R5
   len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_grant |-> (req_issue_len <= req_len) &&
                    (int'(req_issue_len) <= CONV_BUF) &&
                    (int'(req_issue_len) + int'(req_addr[POW-1:0]) <= PAGE_BYTES));

endmodule

// File: tb/tb_rdtrk_top.sv
module tb_rdtrk_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        split_mode = 1'b0;
   logic        bus_locked = 1'b0;
   logic        req_valid = 1'b0;
   logic [1:0]  req_stream = '0;
   logic [31:0] req_addr = '0;
   logic [12:0] req_len = '0;
   logic        req_grant;
   logic        req_refuse;
   logic [12:0] req_issue_len;
   logic [2:0]  req_chunk;
   logic        cpl_valid = 1'b0;
   logic [1:0]  cpl_stream = '0;
   logic [2:0]  cpl_chunk = '0;

   int n_chk  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rdtrk_top dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .split_mode    (split_mode),
      .bus_locked    (bus_locked),
      .req_valid     (req_valid),
      .req_stream    (req_stream),
      .req_addr      (req_addr),
      .req_len       (req_len),
      .req_grant     (req_grant),
      .req_refuse    (req_refuse),
      .req_issue_len (req_issue_len),
      .req_chunk     (req_chunk),
      .cpl_valid     (cpl_valid),
      .cpl_stream    (cpl_stream),
      .cpl_chunk     (cpl_chunk)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   task automatic do_reset(input bit mode);
      @(negedge clk);
      rst_n      = 1'b0;
      split_mode = mode;
      bus_locked = 1'b0;
      req_valid  = 1'b0;
      cpl_valid  = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // one cycle: optional request and completion, checked before the edge
   task automatic op(input bit rv, input int s, input int a, input int l,
                     input bit cv, input int cs, input int cc,
                     input bit eg, input int el, input int ec, input string tag);
      req_valid  = rv;
      req_stream = 2'(s);
      req_addr   = 32'(a);
      req_len    = 13'(l);
      cpl_valid  = cv;
      cpl_stream = 2'(cs);
      cpl_chunk  = 3'(cc);
      #1;
      if (rv) begin
         check({tag, " grant"}, int'(req_grant), int'(eg));
         check({tag, " refuse"}, int'(req_refuse), int'(!eg));
         if (eg) begin
            check({tag, " len"}, int'(req_issue_len), el);
            check({tag, " chunk"}, int'(req_chunk), ec);
         end
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cpl_valid = 1'b0;
   endtask

   task automatic rq(input int s, input bit eg, input int ec, input string tag);
      op(1'b1, s, 0, 64, 1'b0, 0, 0, eg, 64, ec, tag);
   endtask

   task automatic cp(input int s, input int c);
      op(1'b0, 0, 0, 0, 1'b1, s, c, 1'b0, 0, 0, "cpl");
   endtask

   task automatic t_reset;
      do_reset(1'b0);
      rq(0, 1'b1, 0, "R9 conv first");
      do_reset(1'b1);
      rq(2, 1'b1, 0, "R9 split first chunk0");
   endtask

   task automatic t_stream_cap;
      do_reset(1'b0);
      for (int i = 0; i < 4; i++) rq(1, 1'b1, 0, "R1 fill");
      rq(1, 1'b0, 0, "R1 fifth refused");
      rq(1, 1'b0, 0, "R7 repeat refused");
      cp(1, 0);
      rq(1, 1'b1, 0, "R1 slot freed");
      rq(1, 1'b0, 0, "R1 full again");
   endtask

   task automatic t_seg_cap;
      do_reset(1'b0);
      for (int i = 0; i < 4; i++) rq(0, 1'b1, 0, "R2 s0");
      for (int i = 0; i < 4; i++) rq(1, 1'b1, 0, "R2 s1");
      rq(2, 1'b0, 0, "R2 ninth refused");
      rq(3, 1'b0, 0, "R7 refused no count");
      cp(0, 0);
      rq(2, 1'b1, 0, "R2 after one cpl");
      rq(3, 1'b0, 0, "R2 full again");
   endtask

   task automatic t_clip;
      do_reset(1'b0);
      op(1'b1, 0, 'h0F80, 1024, 1'b0, 0, 0, 1'b1, 128, 0, "R5 conv page end");
      op(1'b1, 1, 'h1000, 300, 1'b0, 0, 0, 1'b1, 300, 0, "R5 conv short");
      op(1'b1, 2, 'h0200, 4000, 1'b0, 0, 0, 1'b1, 1024, 0, "R5 conv cap");
      do_reset(1'b1);
      op(1'b1, 0, 'h0100, 4096, 1'b0, 0, 0, 1'b1, 512, 0, "R5 split cap");
      op(1'b1, 0, 'h1FF0, 512, 1'b0, 0, 0, 1'b1, 16, 1, "R5 split page end");
   endtask

   task automatic t_split;
      do_reset(1'b1);
      rq(0, 1'b1, 0, "R3 s0 c0");
      rq(0, 1'b1, 1, "R3 s0 c1");
      rq(1, 1'b1, 2, "R3 s1 c2");
      rq(0, 1'b1, 3, "R3 s0 c3");
      rq(0, 1'b1, 4, "R3 s0 c4");
      rq(0, 1'b0, 0, "R3 stream cap split");
      cp(3, 1);
      rq(0, 1'b1, 1, "R4 freed chunk reused");
      cp(0, 6);
      rq(2, 1'b1, 5, "R4 s2 c5");
      rq(2, 1'b1, 6, "R4 s2 c6");
      rq(3, 1'b1, 7, "R4 s3 c7");
      rq(3, 1'b0, 0, "R4 free-chunk cpl ignored");
      cp(0, 2);
      rq(1, 1'b1, 2, "R4 owner s1 retired");
   endtask

   task automatic t_lock;
      do_reset(1'b0);
      rq(0, 1'b1, 0, "R6 pre");
      rq(0, 1'b1, 0, "R6 pre");
      bus_locked = 1'b1;
      rq(1, 1'b0, 0, "R6 locked refused");
      cp(0, 0);
      bus_locked = 1'b0;
      for (int i = 0; i < 3; i++) rq(0, 1'b1, 0, "R6 cpl during lock");
      rq(0, 1'b0, 0, "R6 cap after lock");
   endtask

   task automatic t_empty_cpl;
      do_reset(1'b0);
      cp(2, 0);
      for (int i = 0; i < 4; i++) rq(2, 1'b1, 0, "R8 no underflow");
      rq(2, 1'b0, 0, "R8 stream cap");
      for (int i = 0; i < 4; i++) rq(0, 1'b1, 0, "R8 seg fill");
      rq(1, 1'b0, 0, "R8 seg cap intact");
   endtask

   task automatic t_simul;
      do_reset(1'b0);
      for (int i = 0; i < 3; i++) rq(0, 1'b1, 0, "R10 pre");
      op(1'b1, 0, 0, 64, 1'b1, 0, 0, 1'b1, 64, 0, "R10 same cycle");
      rq(0, 1'b1, 0, "R10 one slot left");
      rq(0, 1'b0, 0, "R10 net count");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      t_reset();
      t_stream_cap();
      t_seg_cap();
      t_clip();
      t_split();
      t_lock();
      t_empty_cpl();
      t_simul();
      summary();
   end

endmodule